// File: doc/BRIEF.md
# Multicycle Functional Unit Reservation Checker

This block watches the instructions dispatched each cycle to the functional units of one datapath side of a wide-issue processor. Some operation classes hold their unit for more than one cycle. When an instruction of such a class reads an operand over the side's shared cross path, it also holds that path for the same window. The checker keeps one down-counter per unit and one for the cross path. It flags any dispatch that lands on a resource that is still held. It only reports violations: it never stalls, reorders or drops instructions.

Each unit lane carries a valid flag, a 3-bit operation class, the predicate outcome and a cross-path flag. A held resource stays held for its whole window whether or not the instruction's predicate is true. Conflict flags are registered and appear one cycle after the offending dispatch. The busy outputs show the counters live.

Top module: `mfu_resv_checker`

## Requirements
- R1: Class codes map to lock lengths L as follows: 0 gives 1, 1 gives 2, 2 gives 2, 3, 4 and 5 give 4, 6 and 7 give 2. An accepted instruction issued in cycle i drives `unit_busy_o` of its lane high for cycles i+1 through i+L-1 and low from i+L.
- R2: The predicate input has no effect. A false predicate locks the unit for the same window as a true one.
- R3: A valid dispatch to a lane whose `unit_busy_o` is high in that cycle raises that lane's `unit_conflict_o` in the next cycle. Any other cycle shows it low.
- R4: A dispatch in cycle i+L, right after a window ends, is accepted without conflict and starts a new window.
- R5: A conflicting dispatch neither restarts nor lengthens the existing unit lock.
- R6: An accepted instruction with its cross-path flag set holds the cross path for its lock length L. `xpath_busy_o` is high from i+1 through i+L-1.
- R7: A valid dispatch with the cross-path flag set while `xpath_busy_o` is high raises `xpath_conflict_o` in the next cycle. It does not extend the cross-path hold.
- R8: Two or more valid cross-path users in one cycle raise `xpath_conflict_o` in the next cycle. The lowest-numbered user whose unit is free takes the cross-path hold.
- R9: A single-cycle class (code 0) using the cross path holds it for no cycle beyond its issue cycle.
- R10: A synchronous active-high reset clears every lock and every conflict flag from the cycle after it is sampled.
- R11: An instruction that conflicts on its unit takes no cross-path hold. An instruction that conflicts only on the cross path still locks its unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| disp_valid_i | input | NUM_UNITS | Instruction dispatched to lane u |
| disp_class_i | input | 3*NUM_UNITS | Operation class per lane, lane u at bits 3u+2..3u |
| disp_pred_i | input | NUM_UNITS | Predicate outcome per lane (does not affect locking) |
| disp_xpath_i | input | NUM_UNITS | Lane reads a source through the cross path |
| unit_conflict_o | output | NUM_UNITS | Registered: lane was dispatched while locked |
| xpath_conflict_o | output | 1 | Registered: cross-path over-use in the previous cycle |
| unit_busy_o | output | NUM_UNITS | Lane lock counter nonzero |
| xpath_busy_o | output | 1 | Cross-path lock counter nonzero |

## Verification
Every class code is issued once in parallel. This exposes a wrong length per class, and any coupling between lanes. A single lane is then struck inside and at the edge of a 4-cycle window, which separates a late or early release from an improper reload. Cross-path traffic is tried with a held path, with two requesters in one cycle, with single-cycle users, and with a unit-conflicting requester. Each case isolates one of the hold-taking rules. Predicate-false issues and a reset during a live lock complete the set.

// File: rtl/mfu_resv_pkg.sv
package mfu_resv_pkg;

  localparam int CLS_W    = 3;
  localparam int MAX_LOCK = 4;
  localparam int CNT_W    = $clog2(MAX_LOCK);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [CLS_W-1:0] {
    CLS_SINGLE = 3'd0,
    CLS_DCMP   = 3'd1,
    CLS_DADD   = 3'd2,
    CLS_IMUL   = 3'd3,
    CLS_IMUL64 = 3'd4,
    CLS_DMUL   = 3'd5,
    CLS_SDMUL  = 3'd6,
    CLS_SDMUL2 = 3'd7
  } op_class_e;

  // Extra cycles the resource stays held after the issue cycle (length - 1).
  function automatic cnt_t hold_cycles(input logic [CLS_W-1:0] cls);
    cnt_t r;
    case (cls)
      CLS_DCMP, CLS_DADD, CLS_SDMUL, CLS_SDMUL2: r = cnt_t'(1);
      CLS_IMUL, CLS_IMUL64, CLS_DMUL:            r = cnt_t'(MAX_LOCK - 1);
      default:                                   r = '0;
    endcase
    return r;
  endfunction

  // Isolate lowest set bit of a request vector.
  function automatic logic [31:0] lowest_bit(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

endpackage

// File: rtl/mfu_lock_timer.sv
module mfu_lock_timer
  import mfu_resv_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          busy_o
);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                remain_q <= '0;
    else if (load_i)          remain_q <= load_val_i;
    else if (remain_q != '0)  remain_q <= remain_q - CW'(1);
  end

  assign busy_o = (remain_q != '0);

  // R5: the owner must never reload a held resource
  a_r5_no_reload_while_busy: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o |-> !load_i);

  // R1: a nonzero load makes the timer busy next cycle
  a_r1_load_makes_busy: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_i && load_val_i != '0) |=> busy_o);

  // R10: reset releases the hold
  a_r10_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> !busy_o);

endmodule

// File: rtl/mfu_xpath_arbiter.sv
module mfu_xpath_arbiter
  import mfu_resv_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] elig_i,
  output logic [N-1:0] grant_o,
  output logic         multi_o
);

  logic [31:0] cand;
  logic [31:0] pick;

  always_comb begin
    cand = '0;
    cand[N-1:0] = req_i & elig_i;
    pick = lowest_bit(cand);
  end

  assign grant_o = pick[N-1:0];
  assign multi_o = ($countones(req_i) > 1);

  always_comb begin
    a_r8_grant_onehot: assert ($onehot0(grant_o));
    a_r8_grant_subset: assert ((grant_o & ~(req_i & elig_i)) == '0);
  end

endmodule

// File: rtl/mfu_resv_checker.sv
module mfu_resv_checker
  import mfu_resv_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic [NUM_UNITS-1:0]       disp_valid_i,
  input  logic [NUM_UNITS*CLS_W-1:0] disp_class_i,
  input  logic [NUM_UNITS-1:0]       disp_pred_i,
  input  logic [NUM_UNITS-1:0]       disp_xpath_i,
  output logic [NUM_UNITS-1:0]       unit_conflict_o,
  output logic                       xpath_conflict_o,
  output logic [NUM_UNITS-1:0]       unit_busy_o,
  output logic                       xpath_busy_o
);

  // Named internal events
  logic [NUM_UNITS-1:0] unit_hit;     // dispatch onto a held unit
  logic [NUM_UNITS-1:0] unit_accept;  // dispatch onto a free unit
  logic [NUM_UNITS-1:0] run_exec;     // accepted, predicate true
  logic [NUM_UNITS-1:0] run_null;     // accepted, predicate false (still locks)
  logic [NUM_UNITS-1:0] unit_load;
  cnt_t                 hold [NUM_UNITS];

  logic [NUM_UNITS-1:0] xp_req;
  logic [NUM_UNITS-1:0] xp_elig;
  logic [NUM_UNITS-1:0] xp_grant;
  logic                 xp_multi;
  logic                 xp_hit;
  logic                 xp_load;
  cnt_t                 xp_val;

  logic [NUM_UNITS-1:0] unit_conflict_q;
  logic                 xpath_conflict_q;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_lane
    logic [CLS_W-1:0] cls;
    assign cls            = disp_class_i[u*CLS_W +: CLS_W];
    assign hold[u]        = hold_cycles(cls);
    assign unit_hit[u]    = disp_valid_i[u] &  unit_busy_o[u];
    assign unit_accept[u] = disp_valid_i[u] & ~unit_busy_o[u];
    assign run_exec[u]    = unit_accept[u] &  disp_pred_i[u];
    assign run_null[u]    = unit_accept[u] & ~disp_pred_i[u];
    assign unit_load[u]   = run_exec[u] | run_null[u];

    mfu_lock_timer #(.CW(CNT_W)) i_unit_timer (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (unit_load[u]),
      .load_val_i (hold[u]),
      .busy_o     (unit_busy_o[u])
    );

    // R3: dispatch onto a held unit is reported next cycle
    a_r3_conflict_when_busy: assert property (@(posedge clk_i) disable iff (rst_i)
      (disp_valid_i[u] && unit_busy_o[u]) |=> unit_conflict_o[u]);

    // R4: dispatch onto a free unit is clean
    a_r4_clean_issue: assert property (@(posedge clk_i) disable iff (rst_i)
      (disp_valid_i[u] && !unit_busy_o[u]) |=> !unit_conflict_o[u]);

    // R3: no dispatch, no conflict
    a_r3_idle_no_conflict: assert property (@(posedge clk_i) disable iff (rst_i)
      !disp_valid_i[u] |=> !unit_conflict_o[u]);

    // R2: a predicate-false multicycle op still locks its unit
    a_r2_null_still_locks: assert property (@(posedge clk_i) disable iff (rst_i)
      (run_null[u] && hold[u] != '0) |=> unit_busy_o[u]);
  end

  // Cross path
  assign xp_req  = disp_valid_i & disp_xpath_i;
  assign xp_elig = unit_accept & {NUM_UNITS{~xpath_busy_o}};

  mfu_xpath_arbiter #(.N(NUM_UNITS)) i_xpath_arb (
    .req_i   (xp_req),
    .elig_i  (xp_elig),
    .grant_o (xp_grant),
    .multi_o (xp_multi)
  );

  assign xp_hit  = xpath_busy_o & (|xp_req);
  assign xp_load = |xp_grant;

  always_comb begin
    xp_val = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (xp_grant[u]) xp_val = xp_val | hold[u];
    end
  end

  mfu_lock_timer #(.CW(CNT_W)) i_xpath_timer (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (xp_load),
    .load_val_i (xp_val),
    .busy_o     (xpath_busy_o)
  );

  // Registered conflict reports
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      unit_conflict_q  <= '0;
      xpath_conflict_q <= 1'b0;
    end else begin
      unit_conflict_q  <= unit_hit;
      xpath_conflict_q <= xp_hit | xp_multi;
    end
  end

  assign unit_conflict_o  = unit_conflict_q;
  assign xpath_conflict_o = xpath_conflict_q;

  // R7: cross-path use while held is reported
  a_r7_xpath_busy_conflict: assert property (@(posedge clk_i) disable iff (rst_i)
    (xpath_busy_o && (|xp_req)) |=> xpath_conflict_o);

  // R8: simultaneous cross-path users are reported
  a_r8_xpath_dual_use: assert property (@(posedge clk_i) disable iff (rst_i)
    ($countones(xp_req) > 1) |=> xpath_conflict_o);

  // R6: a granted multicycle reader holds the cross path
  a_r6_xpath_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (xp_load && xp_val != '0) |=> xpath_busy_o);

  // R11: a unit-conflicting lane never takes the cross path
  a_r11_no_grant_on_hit: assert property (@(posedge clk_i) disable iff (rst_i)
    (xp_grant & unit_hit) == '0);

  // R10: reset clears conflict flags
  a_r10_flags_cleared: assert property (@(posedge clk_i)
    rst_i |=> (unit_conflict_o == '0 && !xpath_conflict_o));

endmodule

// File: tb/test_mfu_resv_checker.sv
module test_mfu_resv_checker;

  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst;
  logic [N-1:0]   v_in, p_in, x_in;
  logic [3*N-1:0] c_in;
  logic [N-1:0]   uc, ub;
  logic           xc, xb;

  always #2 clk = ~clk;   // 250 MHz

  mfu_resv_checker #(.NUM_UNITS(N)) i_mfu_resv_checker (
    .clk_i(clk), .rst_i(rst),
    .disp_valid_i(v_in), .disp_class_i(c_in), .disp_pred_i(p_in), .disp_xpath_i(x_in),
    .unit_conflict_o(uc), .xpath_conflict_o(xc), .unit_busy_o(ub), .xpath_busy_o(xb)
  );

  typedef struct {
    string        tag;
    logic [N-1:0] uc;
    logic [N-1:0] ub;
    logic         xc;
    logic         xb;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc    = 0;
  int   unit_free [N];
  int   xp_free = 0;
  bit   done = 1'b0;
  int   len_tab [8] = '{1, 2, 2, 4, 4, 4, 2, 2};

  task automatic chk(string tag, string what, logic [N-1:0] act, logic [N-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Driver: applies one cycle of stimulus and predicts its outcome.
  task automatic step(string tag, logic r, logic [N-1:0] v, logic [3*N-1:0] c,
                      logic [N-1:0] p, logic [N-1:0] x);
    exp_t e;
    logic [N-1:0] acc;
    int nreq;
    bit xbusy;
    bit granted;
    @(negedge clk);
    rst = r; v_in = v; c_in = c; p_in = p; x_in = x;
    e.tag = tag; e.uc = '0; e.xc = 1'b0; acc = '0;
    if (r) begin
      for (int u = 0; u < N; u++) unit_free[u] = 0;
      xp_free = 0;
    end else begin
      for (int u = 0; u < N; u++) begin
        e.uc[u] = v[u] && (cyc < unit_free[u]);
        acc[u]  = v[u] && !(cyc < unit_free[u]);
      end
      xbusy = (cyc < xp_free);
      nreq = 0;
      for (int u = 0; u < N; u++) if (v[u] && x[u]) nreq++;
      e.xc = (xbusy && nreq > 0) || (nreq > 1);
      granted = 1'b0;
      if (!xbusy) begin
        for (int u = 0; u < N; u++) begin
          if (!granted && v[u] && x[u] && acc[u]) begin
            granted = 1'b1;
            xp_free = cyc + len_tab[c[3*u +: 3]];
          end
        end
      end
      for (int u = 0; u < N; u++)
        if (acc[u]) unit_free[u] = cyc + len_tab[c[3*u +: 3]];
    end
    for (int u = 0; u < N; u++) e.ub[u] = (cyc + 1) < unit_free[u];
    e.xb = (cyc + 1) < xp_free;
    q.push_back(e);
    cyc++;
  endtask

  task automatic idle(string tag, int n);
    for (int k = 0; k < n; k++) step(tag, 1'b0, '0, '0, '0, '0);
  endtask

  // Monitor: pops predictions and compares after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "unit_conflict", uc, e.uc);
        chk(e.tag, "unit_busy", ub, e.ub);
        chk(e.tag, "xpath_conflict", {3'b0, xc}, {3'b0, e.xc});
        chk(e.tag, "xpath_busy", {3'b0, xb}, {3'b0, e.xb});
      end
    end
  end

  initial begin
    rst = 1'b1; v_in = '0; c_in = '0; p_in = '0; x_in = '0;
    step("R10 reset", 1'b1, '0, '0, '0, '0);
    step("R10 reset", 1'b1, 4'hF, {3'd5, 3'd5, 3'd5, 3'd5}, 4'hF, 4'hF);
    idle("R10 idle", 1);

    // R1: all class lengths, one per lane; lanes independent
    step("R1 classes 5,1,0,6", 1'b0, 4'hF, {3'd6, 3'd0, 3'd1, 3'd5}, 4'hF, '0);
    idle("R1 window", 4);
    step("R1 classes 3,2,4,7", 1'b0, 4'hF, {3'd7, 3'd4, 3'd2, 3'd3}, 4'hF, '0);
    idle("R1 window", 4);

    // R3 / R5 / R4 on lane 0
    step("R3 issue imul", 1'b0, 4'h1, {9'd0, 3'd3}, 4'h1, '0);
    step("R3 hit at i+1", 1'b0, 4'h1, {9'd0, 3'd5}, 4'h1, '0);
    idle("R5 idle", 1);
    step("R5 hit at i+3 no reload", 1'b0, 4'h1, {9'd0, 3'd0}, 4'h1, '0);
    step("R4 issue at i+4", 1'b0, 4'h1, {9'd0, 3'd1}, 4'h1, '0);
    step("R3 hit dcmp window", 1'b0, 4'h1, {9'd0, 3'd0}, 4'h1, '0);
    step("R4 after dcmp", 1'b0, 4'h1, {9'd0, 3'd0}, 4'h1, '0);
    idle("R4 idle", 1);

    // R2: predicate false still locks
    step("R2 pred false imul64", 1'b0, 4'h2, {6'd0, 3'd4, 3'd0}, 4'h0, '0);
    step("R2 hit after null", 1'b0, 4'h2, {6'd0, 3'd0, 3'd0}, 4'h0, '0);
    idle("R2 window", 3);

    // R6 / R7 / R11: cross path held by a multicycle reader
    step("R6 xpath imul lane2", 1'b0, 4'h4, {3'd0, 3'd3, 6'd0}, 4'h4, 4'h4);
    step("R7 xpath use while held", 1'b0, 4'h8, {3'd2, 9'd0}, 4'h8, 4'h8);
    step("R11 unit still locked", 1'b0, 4'h8, {3'd0, 9'd0}, 4'h8, '0);
    idle("R6 window", 1);
    step("R9 single xpath", 1'b0, 4'h8, {3'd0, 9'd0}, 4'h8, 4'h8);
    step("R9 next single xpath", 1'b0, 4'h2, 12'd0, 4'h2, 4'h2);
    idle("R9 idle", 1);

    // R8: two simultaneous cross-path users
    step("R8 dual xpath", 1'b0, 4'hA, {3'd3, 3'd0, 3'd2, 3'd0}, 4'hA, 4'hA);
    step("R8 path held by lane1", 1'b0, 4'h1, {9'd0, 3'd0}, 4'h1, 4'h1);
    step("R8 path free again", 1'b0, 4'h4, {3'd0, 3'd0, 6'd0}, 4'h4, 4'h4);
    idle("R8 idle", 3);

    // R11: unit-conflicting requester takes no cross path
    step("R11 lock lane0", 1'b0, 4'h1, {9'd0, 3'd3}, 4'h1, '0);
    step("R11 hit with xpath", 1'b0, 4'h1, {9'd0, 3'd5}, 4'h1, 4'h1);
    step("R11 path still free", 1'b0, 4'h4, {3'd0, 3'd6, 6'd0}, 4'h4, 4'h4);
    idle("R11 idle", 3);

    // R10: reset during a live lock
    step("R10 lock before reset", 1'b0, 4'hF, {3'd5, 3'd4, 3'd3, 3'd5}, 4'hF, 4'h1);
    step("R10 reset mid-lock", 1'b1, 4'hF, {3'd5, 3'd4, 3'd3, 3'd5}, 4'hF, 4'hF);
    step("R10 after reset", 1'b0, 4'hF, 12'd0, 4'hF, '0);
    idle("R10 idle", 3);

    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule